// File: doc/BRIEF.md
# Microprogrammed Shared-Bus Integer Core

This block is a small integer processor in which every transfer between storage elements crosses one 32-bit shared bus. Four sources can drive that bus: the memory read port, the ALU result, the register array read port and the immediate extender. A microcode ROM steps through control words. Each control word selects one bus source and raises the load or write strobes of whichever storage elements should capture the bus value on that clock edge.

The register array holds 32 general registers and the program counter, which sits at index 32. A memory address latch drives the word-addressed memory port. The ALU takes its operands from two input latches, A and B. A fixed fetch routine reads the instruction at the PC, advances the PC by four through the ALU, and then jumps to a per-instruction routine that performs a register-register or register-immediate ALU operation. The memory model sits outside the block and may stall any read by raising a busy line.

A read-only register view port lets the surrounding logic inspect the register array and the PC without disturbing execution.

Top module: `mcBusCpu`

## Requirements
- R1: While reset is low and right after it is released, the PC and every general register read as 0 through the view port, and the memory address output is 0.
- R2: Instruction words are fetched from consecutive byte addresses 0, 4, 8, and so on. After the N-th fetch, the PC (view index 32) reads 4*N.
- R3: While a memory read is requested and memBusy is high, the core holds its step: memRe stays high and memAddr is unchanged on the next cycle. Results do not depend on how long memory stays busy.
- R4: Register-register instructions use opcode bits [31:26]=0, source fields [25:21] and [20:16], destination field [15:11], and function field [5:0]. Function 0x20 adds, 0x22 subtracts the second source from the first, 0x24 performs AND and 0x25 performs OR. All arithmetic is modulo 2^32.
- R5: Immediate instructions take their source from field [25:21] and write their destination at field [20:16]. The operand is bits [15:0], sign-extended. Opcode 0x08 adds, 0x09 subtracts, 0x0C performs AND and 0x0D performs OR.
- R6: Register 0 always reads as 0, and any write that targets it is dropped.
- R7: An instruction with any other opcode, or with opcode 0 and any other function code, changes no register except the PC, which still advances by 4.
- R8: At most one bus source is enabled in any cycle. During the instruction read, the bus (memWdata) carries the memory data.
- R9: With memBusy held low, a supported instruction takes 8 cycles from one instruction read to the next, and an unsupported one takes 5.
- R10: memWe is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 32 | Byte address held in the memory address latch |
| memRe | output | 1 | Memory read request; the memory drives memRdata combinationally |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 32 | Current shared-bus value |
| memRdata | input | 32 | Memory read data |
| memBusy | input | 1 | Memory not ready; the current step is repeated |
| dbgSel | input | 6 | View port index: 0 to 31 for general registers, 32 for the PC |
| dbgData | output | 32 | Value at dbgSel; 0 for register 0 and for indices above 32 |

## Verification
A wrong microcode word or a wrong dispatch target shows up at the next instruction read. The gap between reads is 8 or 5 cycles, and the read address no longer follows PC+4, so either fault surfaces within one instruction. A corrupted operand latch or a wrong register index does not surface until the register image is compared after the program ends. The program therefore sweeps all four operations in both formats, across register pairs that include r0, r31 and equal sources. A stall-handling fault appears as a changed address during a busy cycle, or as a register image that differs between the stalled and the unstalled run.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_GPR   = 32;
  localparam int PC_IDX    = 32;
  localparam int LINK_IDX  = 31;
  localparam int UPC_W     = 5;

  // microcode layout: fetch routine, then 4 reg-reg routines, then 4 immediate routines
  localparam int FETCH_LEN   = 5;
  localparam int ROUTINE_LEN = 3;
  localparam int NUM_OPS     = 4;
  localparam int R_BASE      = FETCH_LEN;
  localparam int I_BASE      = R_BASE + NUM_OPS * ROUTINE_LEN;
  localparam int ROM_DEPTH   = I_BASE + NUM_OPS * ROUTINE_LEN;

  localparam logic [5:0] OPC_REGREG = 6'h00;
  localparam logic [5:0] OPC_ADDI   = 6'h08;
  localparam logic [5:0] OPC_SUBI   = 6'h09;
  localparam logic [5:0] OPC_ANDI   = 6'h0C;
  localparam logic [5:0] OPC_ORI    = 6'h0D;
  localparam logic [5:0] FN_ADD     = 6'h20;
  localparam logic [5:0] FN_SUB     = 6'h22;
  localparam logic [5:0] FN_AND     = 6'h24;
  localparam logic [5:0] FN_OR      = 6'h25;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} aluop_e;
  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_FOUR, EXT_HIGH} extsel_e;
  typedef enum logic [2:0] {SEL_RS, SEL_RT, SEL_RD, SEL_PC, SEL_LINK} regsel_e;
  typedef enum logic [1:0] {SEQ_NEXT, SEQ_DISP, SEQ_FETCH} seq_e;

  // the 17 control lines of one microinstruction
  typedef struct packed {
    logic    ldMa;
    logic    ldA;
    logic    ldB;
    logic    ldIr;
    logic    regWr;
    logic    memWr;
    logic    enMem;
    logic    enAlu;
    logic    enReg;
    logic    enImm;
    aluop_e  aluOp;
    extsel_e extSel;
    regsel_e regSel;
  } strobes_t;

  typedef struct packed {
    strobes_t s;
    seq_e     seq;
  } uword_t;
endpackage

// File: rtl/mcbControl.sv
module mcbControl
  import mcb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       memBusy,
  output strobes_t   ctrl
);
  logic [UPC_W-1:0] uPc;
  logic [UPC_W-1:0] uPcNext;
  uword_t           uw;
  logic             stall;

  function automatic uword_t romWord(input logic [UPC_W-1:0] a);
    uword_t w;
    int     idx;
    int     rel;
    int     op;
    int     step;
    logic   isImm;
    w     = '0;
    idx   = int'(a);
    isImm = 1'b0;
    rel   = 0;
    if (idx == 0) begin
      w.s.regSel = SEL_PC; w.s.enReg = 1'b1; w.s.ldMa = 1'b1;
    end else if (idx == 1) begin
      w.s.regSel = SEL_PC; w.s.enReg = 1'b1; w.s.ldA = 1'b1;
    end else if (idx == 2) begin
      w.s.enMem = 1'b1; w.s.ldIr = 1'b1;
    end else if (idx == 3) begin
      w.s.enImm = 1'b1; w.s.extSel = EXT_FOUR; w.s.ldB = 1'b1;
    end else if (idx == 4) begin
      w.s.enAlu = 1'b1; w.s.aluOp = ALU_ADD; w.s.regSel = SEL_PC;
      w.s.regWr = 1'b1; w.seq = SEQ_DISP;
    end else if (idx < ROM_DEPTH) begin
      isImm = (idx >= I_BASE);
      rel   = idx - (isImm ? I_BASE : R_BASE);
      op    = rel / ROUTINE_LEN;
      step  = rel % ROUTINE_LEN;
      if (step == 0) begin
        w.s.regSel = SEL_RS; w.s.enReg = 1'b1; w.s.ldA = 1'b1;
      end else if (step == 1) begin
        if (isImm) begin
          w.s.enImm = 1'b1; w.s.extSel = EXT_SIGN; w.s.ldB = 1'b1;
        end else begin
          w.s.regSel = SEL_RT; w.s.enReg = 1'b1; w.s.ldB = 1'b1;
        end
      end else begin
        w.s.enAlu  = 1'b1;
        w.s.aluOp  = aluop_e'(op[1:0]);
        w.s.regSel = isImm ? SEL_RT : SEL_RD;
        w.s.regWr  = 1'b1;
        w.seq      = SEQ_FETCH;
      end
    end else begin
      w.seq = SEQ_FETCH;
    end
    return w;
  endfunction

  function automatic logic [UPC_W-1:0] dispatchTarget(input logic [5:0] opc, input logic [5:0] fn);
    logic       valid;
    logic [1:0] op;
    int         base;
    valid = 1'b1;
    op    = 2'd0;
    if (opc == OPC_REGREG) begin
      base = R_BASE;
      case (fn)
        FN_ADD:  op = 2'd0;
        FN_SUB:  op = 2'd1;
        FN_AND:  op = 2'd2;
        FN_OR:   op = 2'd3;
        default: valid = 1'b0;
      endcase
    end else begin
      base = I_BASE;
      case (opc)
        OPC_ADDI: op = 2'd0;
        OPC_SUBI: op = 2'd1;
        OPC_ANDI: op = 2'd2;
        OPC_ORI:  op = 2'd3;
        default:  valid = 1'b0;
      endcase
    end
    return valid ? UPC_W'(base + ROUTINE_LEN * int'(op)) : '0;
  endfunction

  assign uw    = romWord(uPc);
  assign stall = uw.s.enMem && memBusy;

  always_comb begin
    ctrl = uw.s;
    if (stall) begin
      ctrl.ldMa  = 1'b0;
      ctrl.ldA   = 1'b0;
      ctrl.ldB   = 1'b0;
      ctrl.ldIr  = 1'b0;
      ctrl.regWr = 1'b0;
      ctrl.memWr = 1'b0;
    end
  end

  always_comb begin
    if (stall) begin
      uPcNext = uPc;
    end else begin
      case (uw.seq)
        SEQ_NEXT:  uPcNext = uPc + UPC_W'(1);
        SEQ_DISP:  uPcNext = dispatchTarget(opcode, funct);
        default:   uPcNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) uPc <= '0;
    else       uPc <= uPcNext;
  end

  AST_HOLD_ON_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (uw.s.enMem && memBusy) |=> (uPc == $past(uPc))); // R3
  AST_NO_MEM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.memWr); // R10
  AST_DISPATCH_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (uw.seq == SEQ_DISP && !stall) |=> (int'(uPc) == 0 || int'(uPc) >= R_BASE)); // R7
endmodule

// File: rtl/mcbDatapath.sv
module mcbDatapath
  import mcb_pkg::*;
#(
  parameter int DataW   = DATA_W,
  parameter int NumRegs = NUM_GPR + 1,
  parameter int IdxW    = $clog2(NumRegs)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         ctrl,
  input  logic [DataW-1:0] memRdata,
  input  logic [IdxW-1:0]  dbgSel,
  output logic [DataW-1:0] dbgData,
  output logic [DataW-1:0] memAddr,
  output logic [DataW-1:0] busVal,
  output logic [5:0]       opcode,
  output logic [5:0]       funct
);
  localparam logic [IdxW-1:0] LAST_IDX = IdxW'(NumRegs - 1);

  logic [DataW-1:0] regFile [NumRegs];
  logic [DataW-1:0] maReg;
  logic [DataW-1:0] aReg;
  logic [DataW-1:0] bReg;
  logic [DataW-1:0] irReg;
  logic [IdxW-1:0]  regIdx;
  logic [DataW-1:0] regRead;
  logic [DataW-1:0] immVal;
  logic [DataW-1:0] aluOut;

  function automatic logic [DataW-1:0] readReg(input logic [IdxW-1:0] idx);
    if (idx == '0 || idx > LAST_IDX) return '0;
    return regFile[idx];
  endfunction

  assign opcode = irReg[31:26];
  assign funct  = irReg[5:0];

  always_comb begin
    case (ctrl.regSel)
      SEL_RS:   regIdx = IdxW'(irReg[25:21]);
      SEL_RT:   regIdx = IdxW'(irReg[20:16]);
      SEL_RD:   regIdx = IdxW'(irReg[15:11]);
      SEL_PC:   regIdx = IdxW'(PC_IDX);
      SEL_LINK: regIdx = IdxW'(LINK_IDX);
      default:  regIdx = '0;
    endcase
  end

  assign regRead = readReg(regIdx);
  assign dbgData = readReg(dbgSel);

  always_comb begin
    case (ctrl.extSel)
      EXT_SIGN: immVal = {{(DataW-16){irReg[15]}}, irReg[15:0]};
      EXT_ZERO: immVal = {{(DataW-16){1'b0}}, irReg[15:0]};
      EXT_FOUR: immVal = DataW'(4);
      default:  immVal = {irReg[15:0], {(DataW-16){1'b0}}};
    endcase
  end

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD: aluOut = aReg + bReg;
      ALU_SUB: aluOut = aReg - bReg;
      ALU_AND: aluOut = aReg & bReg;
      default: aluOut = aReg | bReg;
    endcase
  end

  // shared bus: one source at a time, selected by its enable
  always_comb begin
    busVal = '0;
    if (ctrl.enMem) busVal = memRdata;
    if (ctrl.enAlu) busVal = aluOut;
    if (ctrl.enReg) busVal = regRead;
    if (ctrl.enImm) busVal = immVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maReg <= '0;
      aReg  <= '0;
      bReg  <= '0;
      irReg <= '0;
      for (int i = 0; i < NumRegs; i++) regFile[i] <= '0;
    end else begin
      if (ctrl.ldMa) maReg <= busVal;
      if (ctrl.ldA)  aReg  <= busVal;
      if (ctrl.ldB)  bReg  <= busVal;
      if (ctrl.ldIr) irReg <= busVal;
      if (ctrl.regWr && regIdx != '0 && regIdx <= LAST_IDX) regFile[regIdx] <= busVal;
    end
  end

  assign memAddr = maReg;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.enMem, ctrl.enAlu, ctrl.enReg, ctrl.enImm})); // R8
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.regWr && ctrl.regSel == SEL_PC) |-> (busVal == aReg + DataW'(4))); // R2
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dbgSel == '0) |-> (dbgData == '0)); // R6
  AST_MA_FROM_PC: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.ldMa |=> (memAddr[1:0] == 2'b00)); // R2
endmodule

// File: rtl/mcBusCpu.sv
module mcBusCpu
  import mcb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] memAddr,
  output logic        memRe,
  output logic        memWe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memBusy,
  input  logic [5:0]  dbgSel,
  output logic [31:0] dbgData
);
  strobes_t   strobes;
  logic [5:0] opcode;
  logic [5:0] funct;

  mcbControl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .funct   (funct),
    .memBusy (memBusy),
    .ctrl    (strobes)
  );

  mcbDatapath #(
    .DataW   (DATA_W),
    .NumRegs (NUM_GPR + 1),
    .IdxW    (6)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (strobes),
    .memRdata (memRdata),
    .dbgSel   (dbgSel),
    .dbgData  (dbgData),
    .memAddr  (memAddr),
    .busVal   (memWdata),
    .opcode   (opcode),
    .funct    (funct)
  );

  assign memRe = strobes.enMem;
  assign memWe = strobes.memWr;
endmodule

// File: tb/tb_mcBusCpu.sv
`timescale 1ns/100ps
module tb_mcBusCpu;
  localparam int NPROG = 48;
  localparam logic [31:0] NOP_WORD = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr;
  logic        memRe;
  logic        memWe;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        memBusy = 1'b0;
  logic [5:0]  dbgSel = '0;
  logic [31:0] dbgData;

  always #2 clk = ~clk;

  mcBusCpu dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .memBusy(memBusy),
    .dbgSel(dbgSel), .dbgData(dbgData)
  );

  logic [31:0] prog [NPROG];
  logic [31:0] mreg [32];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always_comb begin
    if ((memAddr >> 2) < NPROG) memRdata = prog[memAddr[7:2]];
    else                        memRdata = NOP_WORD;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkR(input int op, input int rd, input int rs, input int rt);
    logic [5:0] fn;
    case (op % 4)
      0: fn = 6'h20; 1: fn = 6'h22; 2: fn = 6'h24; default: fn = 6'h25;
    endcase
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] mkI(input int op, input int rt, input int rs, input logic [15:0] imm);
    logic [5:0] opc;
    case (op % 4)
      0: opc = 6'h08; 1: opc = 6'h09; 2: opc = 6'h0C; default: opc = 6'h0D;
    endcase
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] genInstr(input int k);
    logic [15:0] seeds [8];
    seeds = '{16'd5, 16'hFFFD, 16'h7FFF, 16'h8000, 16'h1234, 16'd1, 16'hFFFF, 16'h00FF};
    if (k < 8)  return mkI(0, k + 1, 0, seeds[k]);
    if (k < 40) begin
      if (k % 2 == 0) return mkR((k / 2) % 4, (k * 7) % 32, (k * 3) % 32, (k * 5) % 32);
      return mkI((k / 2) % 4, (k * 11) % 32, (k * 13) % 32, 16'((k * 4099) ^ 32'h8a5c));
    end
    case (k)
      40: return {6'h3F, 5'd1, 5'd2, 16'h0010};
      41: return {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h21};
      42: return {6'h0B, 5'd4, 5'd5, 16'h0001};
      43: return mkI(0, 0, 5, 16'd7);
      44: return mkR(0, 0, 1, 2);
      45: return mkR(3, 31, 0, 4);
      46: return mkI(3, 30, 0, 16'hFFFF);
      default: return mkR(1, 29, 30, 31);
    endcase
  endfunction

  function automatic bit isSupported(input logic [31:0] w);
    if (w[31:26] == 6'h00)
      return (w[5:0] == 6'h20 || w[5:0] == 6'h22 || w[5:0] == 6'h24 || w[5:0] == 6'h25);
    return (w[31:26] == 6'h08 || w[31:26] == 6'h09 || w[31:26] == 6'h0C || w[31:26] == 6'h0D);
  endfunction

  function automatic logic [31:0] instrAt(input int k);
    return (k < NPROG) ? prog[k] : NOP_WORD;
  endfunction

  // reference model (R4, R5, R6, R7)
  task automatic modelRun();
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int k = 0; k < NPROG; k++) begin
      logic [31:0] w, a, b, res;
      int dest, sel;
      w = prog[k];
      if (!isSupported(w)) continue;
      a = mreg[w[25:21]];
      if (w[31:26] == 6'h00) begin
        b = mreg[w[20:16]]; dest = int'(w[15:11]);
        sel = (w[5:0] == 6'h20) ? 0 : (w[5:0] == 6'h22) ? 1 : (w[5:0] == 6'h24) ? 2 : 3;
      end else begin
        b = {{16{w[15]}}, w[15:0]}; dest = int'(w[20:16]);
        sel = (w[31:26] == 6'h08) ? 0 : (w[31:26] == 6'h09) ? 1 : (w[31:26] == 6'h0C) ? 2 : 3;
      end
      case (sel)
        0: res = a + b; 1: res = a - b; 2: res = a & b; default: res = a | b;
      endcase
      if (dest != 0) mreg[dest] = res;
    end
  endtask

  // port monitor: busy pattern, fetch order, stall hold, timing
  int cycleCnt = 0;
  always @(posedge clk) cycleCnt++;

  bit          busyEn = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          fetchCnt = 0;
  int          lastFetchCycle = 0;
  bit          prevHold = 0;
  logic [31:0] prevAddr = '0;

  always @(negedge clk) begin
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memBusy = busyEn && lfsr[0];
    #0.5;
    if (!rstN) begin
      fetchCnt = 0;
      prevHold = 0;
    end else begin
      if (prevHold && memRe) chk(memAddr == prevAddr, "R3 address held while busy", memAddr, prevAddr);
      prevHold = memRe && memBusy;
      prevAddr = memAddr;
      if (memRe && !memBusy) begin
        chk(memAddr == 32'(fetchCnt * 4), "R2 fetch address", memAddr, 32'(fetchCnt * 4));
        chk(memWe == 1'b0, "R10 write strobe", 32'(memWe), 32'd0);
        chk(memWdata == memRdata, "R8 bus carries memory data", memWdata, memRdata);
        if (!busyEn && fetchCnt > 0) begin
          int expGap;
          expGap = isSupported(instrAt(fetchCnt - 1)) ? 8 : 5;
          chk(cycleCnt - lastFetchCycle == expGap, "R7/R9 cycles per instruction",
              32'(cycleCnt - lastFetchCycle), 32'(expGap));
        end
        lastFetchCycle = cycleCnt;
        fetchCnt++;
      end
    end
  end

  task automatic runProgram(input bit withBusy);
    rstN   = 1'b0;
    busyEn = withBusy;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    dbgSel = 6'd1;  #0.1; chk(dbgData == 32'd0, "R1 register cleared by reset", dbgData, 32'd0);
    dbgSel = 6'd32; #0.1; chk(dbgData == 32'd0, "R1 PC cleared by reset", dbgData, 32'd0);
    chk(memAddr == 32'd0, "R1 address after reset", memAddr, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    modelRun();
    wait (fetchCnt == NPROG + 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    for (int i = 0; i < 32; i++) begin
      dbgSel = 6'(i);
      #0.1;
      if (i == 0) chk(dbgData == 32'd0, "R6 register 0", dbgData, 32'd0);
      else        chk(dbgData == mreg[i], withBusy ? "R3/R4/R5 register image with stalls" : "R4/R5/R7 register image",
                      dbgData, mreg[i]);
    end
    dbgSel = 6'd32; #0.1;
    chk(dbgData == 32'(4 * (NPROG + 1)), "R2 final PC", dbgData, 32'(4 * (NPROG + 1)));
    dbgSel = 6'd40; #0.1;
    chk(dbgData == 32'd0, "R6 out-of-range view index", dbgData, 32'd0);
  endtask

  initial begin
    for (int k = 0; k < NPROG; k++) prog[k] = genInstr(k);
    runProgram(1'b0);
    runProgram(1'b1);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", fetchCnt, NPROG + 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule